// File: doc/BRIEF.md
# JTAG Scan Master

This block drives a JTAG test access port from a fast system clock. The host hands it one command at a time: an instruction-register scan, a data-register scan, or a TAP reset. The engine then produces TCK, TMS and TDI by counting system clocks. It walks the target's TAP from Run-Test-Idle into the selected shift state, moves the requested number of bits, and returns through Update to Run-Test-Idle. While doing this it collects the bits arriving on TDO.

A scan carries up to 32 bits. They leave on TDI lowest bit first. The returned word is right-aligned, so the bit captured first lands in bit 0. A divider input sets the length of each TCK half-period in system clocks. The host must choose it so that TCK stays at or below one eighth of the target's core clock. When the engine finishes, `busy` drops and `done` pulses for a single cycle. The captured word stays on `rdata` until the next command is accepted.

Top module: `jtag_scan_master`

## Requirements
- R1: After reset, `tck`, `tms`, `tdi`, `busy` and `done` are all 0.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1 and `busy` is 0, and `busy` is 1 after that edge. A `cmd_valid` seen while `busy` is 1 is ignored: it produces no TCK activity and no extra scan.
- R3: `cmd_kind` 0 selects a data scan of N bits. It takes N+5 TCK cycles. TMS, as sampled at the successive rising edges, is 1,0,0, then N shift cycles with TMS 1 only on the last one, then 1,0.
- R4: `cmd_kind` 1 selects an instruction scan of N bits. It takes N+6 TCK cycles, with TMS 1,1,0,0, then N shift cycles with TMS 1 only on the last one, then 1,0.
- R5: During the k-th shift cycle (k from 0), TDI carries bit k of `cmd_data`. Outside shift cycles TDI is 0.
- R6: The TDO value present at the rising edge of the k-th shift cycle appears in `rdata[k]` when the scan ends. Bits N and above are 0.
- R7: `cmd_kind` 2 or 3 selects a TAP reset. It takes six TCK cycles with TMS 1,1,1,1,1,0 and TDI 0, and it leaves `rdata` at 0.
- R8: Each TCK low phase and each high phase lasts `half_div` system clocks, with 0 treated as 1. The value is taken when the command is accepted. Every cycle starts with the low phase.
- R9: TMS and TDI never change on the system clock edge where TCK rises.
- R10: `done` is a single-cycle pulse that coincides with `busy` falling. `rdata` holds its value while the engine is idle.
- R11: A `cmd_len` of 0 is treated as 1, and any value above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | 8 | TCK half-period in system clocks (0 acts as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | 0 data scan, 1 instruction scan, 2/3 TAP reset |
| cmd_len | input | 6 | Number of bits to shift (1 to 32) |
| cmd_data | input | 32 | Bits to shift out, lowest first |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan strobe |
| rdata | output | 32 | Captured TDO word, right-aligned |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
A wrong sequencer state shows up on TMS at the very next rising TCK edge. It appears as a wrong step in the 1,0,0 or 1,1,0,0 preamble, a TMS pulse that comes early or late around the last shifted bit, or a total edge count that differs from N+5 or N+6. A fault in the shift or capture path appears bit by bit on TDI while the scan runs, and in the placement of the captured bits in `rdata` when `done` pulses. A fault in the divider shows in the length of the very first TCK low phase.

// File: rtl/jsm_pkg.sv
`timescale 1ns/1ps
package jsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_POST  = 2'd3
    } jsm_state_e;

    localparam logic [1:0] KIND_DR = 2'd0;
    localparam logic [1:0] KIND_IR = 2'd1;

    // TMS walk patterns from Run-Test-Idle, consumed from bit 0 upward
    localparam logic [5:0] PAT_DR  = 6'b000001;
    localparam logic [5:0] PAT_IR  = 6'b000011;
    localparam logic [5:0] PAT_RST = 6'b011111;

    localparam logic [2:0] LEN_PRE_DR  = 3'd3;
    localparam logic [2:0] LEN_PRE_IR  = 3'd4;
    localparam logic [2:0] LEN_PRE_RST = 3'd6;

endpackage

// File: rtl/jsm_tck_gen.sv
`timescale 1ns/1ps
module jsm_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tck,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic             phase;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] hd;
    } tg_t;

    tg_t d, q;
    logic half_end;

    assign half_end = run && (q.cnt == q.hd - DIV_W'(1));
    assign rise     = half_end && !q.phase;
    assign fall     = half_end && q.phase;
    assign tck      = q.phase;

    always_comb begin
        d = q;
        if (!run) begin
            d.phase = 1'b0;
            d.cnt   = '0;
            d.hd    = (half_div == '0) ? DIV_W'(1) : half_div;
        end else if (half_end) begin
            d.cnt   = '0;
            d.phase = !q.phase;
        end else begin
            d.cnt   = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= 1'b0;
            q.cnt   <= '0;
            q.hd    <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    // R8
    hd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(q.hd));

endmodule

// File: rtl/jsm_shift_acc.sv
`timescale 1ns/1ps
module jsm_shift_acc #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] load_data,
    input  logic [LEN_W-1:0]    load_len,
    input  logic                sample,
    input  logic                tdo_i,
    input  logic                advance,
    output logic                tdi_bit,
    output logic [MAX_BITS-1:0] acc
);

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic [MAX_BITS-1:0] acc;
        logic [LEN_W-1:0]    len;
    } sa_t;

    sa_t d, q;

    assign tdi_bit = q.data[0];
    assign acc     = q.acc;

    always_comb begin
        d = q;
        if (load) begin
            d.data = load_data;
            d.acc  = '0;
            d.len  = load_len;
        end else begin
            if (sample) begin
                d.acc = q.acc >> 1;
                for (int i = 0; i < MAX_BITS; i++) begin
                    if (i == int'(q.len) - 1) d.acc[i] = tdo_i;
                end
            end
            if (advance) d.data = q.data >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6
    capture_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !load) |=> (((q.acc >> (q.len - LEN_W'(1))) & MAX_BITS'(1)) == MAX_BITS'($past(tdo_i))));

endmodule

// File: rtl/jtag_scan_master.sv
`timescale 1ns/1ps
module jtag_scan_master
    import jsm_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int DIV_W    = 8,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rdata,
    output logic                tck,
    output logic                tms,
    output logic                tdi,
    input  logic                tdo
);

    typedef struct packed {
        jsm_state_e       st;
        logic [1:0]       kind;
        logic [5:0]       pat;
        logic [2:0]       pre_left;
        logic [LEN_W-1:0] bit_left;
        logic [1:0]       post_left;
        logic             done;
    } fsm_t;

    fsm_t d, q;

    logic             accept;
    logic             rise, fall;
    logic             tdi_bit;
    logic [LEN_W-1:0] eff_len;
    logic             run;

    assign run     = (q.st != ST_IDLE);
    assign accept  = cmd_valid && !run;
    assign eff_len = (cmd_len == '0) ? LEN_W'(1) :
                     (cmd_len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : cmd_len;

    jsm_tck_gen #(.DIV_W(DIV_W)) tck_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .tck      (tck),
        .rise     (rise),
        .fall     (fall)
    );

    jsm_shift_acc #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) shift_acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (cmd_data),
        .load_len  (eff_len),
        .sample    (rise && (q.st == ST_SHIFT)),
        .tdo_i     (tdo),
        .advance   (fall && (q.st == ST_SHIFT)),
        .tdi_bit   (tdi_bit),
        .acc       (rdata)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st        = ST_PRE;
                    d.kind      = cmd_kind;
                    d.bit_left  = eff_len;
                    d.post_left = 2'd2;
                    if (cmd_kind == KIND_DR) begin
                        d.pat      = PAT_DR;
                        d.pre_left = LEN_PRE_DR;
                    end else if (cmd_kind == KIND_IR) begin
                        d.pat      = PAT_IR;
                        d.pre_left = LEN_PRE_IR;
                    end else begin
                        d.pat      = PAT_RST;
                        d.pre_left = LEN_PRE_RST;
                    end
                end
            end
            ST_PRE: begin
                if (fall) begin
                    d.pat      = q.pat >> 1;
                    d.pre_left = q.pre_left - 3'd1;
                    if (q.pre_left == 3'd1) begin
                        if (q.kind == KIND_DR || q.kind == KIND_IR) begin
                            d.st = ST_SHIFT;
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end
                end
            end
            ST_SHIFT: begin
                if (fall) begin
                    d.bit_left = q.bit_left - LEN_W'(1);
                    if (q.bit_left == LEN_W'(1)) d.st = ST_POST;
                end
            end
            ST_POST: begin
                if (fall) begin
                    d.post_left = q.post_left - 2'd1;
                    if (q.post_left == 2'd1) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.kind      <= '0;
            q.pat       <= '0;
            q.pre_left  <= '0;
            q.bit_left  <= '0;
            q.post_left <= '0;
            q.done      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            ST_PRE:   tms = q.pat[0];
            ST_SHIFT: tms = (q.bit_left == LEN_W'(1));
            ST_POST:  tms = (q.post_left == 2'd2);
            default:  tms = 1'b0;
        endcase
    end

    assign tdi  = (q.st == ST_SHIFT) ? tdi_bit : 1'b0;
    assign busy = run;
    assign done = q.done;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tck && !tms && !tdi));

    // R9
    rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> ($stable(tms) && $stable(tdi)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !$past(cmd_valid)) |-> $stable(rdata));

endmodule

// File: tb/jtag_scan_master_tb_top.sv
`timescale 1ns/1ps
module jtag_scan_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [5:0]  cmd_len = 6'd1;
    logic [31:0] cmd_data = '0;
    logic        busy, done, tck, tms, tdi, tdo;
    logic [31:0] rdata;

    always #4 clk = ~clk;

    jtag_scan_master dut_i (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_len(cmd_len),
        .cmd_data(cmd_data), .busy(busy), .done(done), .rdata(rdata),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    localparam logic [63:0] TDO_PAT = 64'hC3A5_9F10_6E2B_D478;

    typedef struct {
        int          kind;
        int          len;
        logic [31:0] data;
        int          hd;
        string       tag;
    } item_t;

    item_t sb_q[$];

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // target model: TDO follows a fixed pattern indexed by rising-edge count
    int       rise_cnt = 0;
    assign tdo = TDO_PAT[rise_cnt[5:0]];

    bit       tms_log [0:63];
    bit       tdi_log [0:63];
    int       run_len = 0;
    bit       t_err = 0;
    bit       prev_tck = 0, prev_busy = 0, prev_tms = 0, prev_tdi = 0;
    logic [31:0] last_rdata = '0;

    function automatic int pre_len(input int kind);
        if (kind == 0) return 3;
        if (kind == 1) return 4;
        return 6;
    endfunction

    // monitor: logs TAP edges and compares with the expected item on done
    always @(negedge clk) begin
        int hd_e;
        hd_e = (sb_q.size() > 0) ? sb_q[0].hd : 1;
        if (busy && !prev_busy) begin
            rise_cnt = 0;
            run_len  = 1;
            t_err    = 0;
        end else if (busy) begin
            if (tck == prev_tck) run_len++;
            else begin
                if (run_len != hd_e) t_err = 1;
                run_len = 1;
            end
        end
        if (busy && tck && !prev_tck) begin
            if (tms != prev_tms || tdi != prev_tdi) t_err = 1;
            if (rise_cnt < 64) begin
                tms_log[rise_cnt] = tms;
                tdi_log[rise_cnt] = tdi;
            end
            rise_cnt++;
        end
        if (done) begin
            item_t it;
            int p, tot, nt, nd;
            logic [31:0] exp_r;
            string rq;
            if (prev_tck && run_len != hd_e) t_err = 1;
            if (sb_q.size() == 0) begin
                chk(0, "R2", "unexpected done", 1, 0);
            end else begin
                it  = sb_q.pop_front();
                p   = pre_len(it.kind);
                tot = (it.kind >= 2) ? 6 : p + it.len + 2;
                rq  = (it.kind == 0) ? "R3" : (it.kind == 1) ? "R4" : "R7";
                nt = 0; nd = 0; exp_r = '0;
                for (int i = 0; i < tot && i < 64; i++) begin
                    bit et, ed;
                    if (it.kind >= 2) begin
                        et = (i < 5); ed = 0;
                    end else if (i < p) begin
                        et = (i == 0) || (it.kind == 1 && i == 1); ed = 0;
                    end else if (i < p + it.len) begin
                        et = (i == p + it.len - 1); ed = it.data[i - p];
                    end else begin
                        et = (i == p + it.len); ed = 0;
                    end
                    if (tms_log[i] != et) nt++;
                    if (tdi_log[i] != ed) nd++;
                end
                if (it.kind < 2)
                    for (int k = 0; k < it.len; k++) exp_r[k] = TDO_PAT[p + k];
                chk(rise_cnt == tot, {rq, " ", it.tag}, "TCK cycle count", 64'(rise_cnt), 64'(tot));
                chk(nt == 0, {rq, " ", it.tag}, "TMS mismatches", 64'(nt), 0);
                chk(nd == 0, {"R5 ", it.tag}, "TDI mismatches", 64'(nd), 0);
                chk(rdata == exp_r, {"R6 ", it.tag}, "captured word", 64'(rdata), 64'(exp_r));
                chk(!t_err, {"R8 R9 ", it.tag}, "phase length or edge stability", 64'(t_err), 0);
                last_rdata = rdata;
            end
        end
        prev_tck  = tck;
        prev_busy = busy;
        prev_tms  = tms;
        prev_tdi  = tdi;
    end

    // driver: pushes the expected item, issues the command, waits for completion
    task automatic send(input int kind, input int len, input logic [31:0] data,
                        input int hd, input string tag, input bit inject);
        item_t it;
        it.kind = kind;
        it.len  = (len == 0) ? 1 : (len > 32 ? 32 : len);
        it.data = data;
        it.hd   = (hd == 0) ? 1 : hd;
        it.tag  = tag;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_kind  = kind[1:0];
        cmd_len   = len[5:0];
        cmd_data  = data;
        half_div  = hd[7:0];
        cmd_valid = 1'b1;
        sb_q.push_back(it);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (inject) begin
            // R2: a second request while busy must be ignored
            repeat (5) @(negedge clk);
            cmd_kind  = 2'd1;
            cmd_len   = 6'd7;
            cmd_data  = 32'hFFFF_FFFF;
            half_div  = 8'd9;
            cmd_valid = 1'b1;
            repeat (4) @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", 64'(done), 0);
        repeat (3) @(negedge clk);
        chk(rdata == last_rdata, "R10", "rdata held while idle", 64'(rdata), 64'(last_rdata));
    endtask

    initial begin
        int n;
        #1;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk({tck, tms, tdi, busy, done} == 5'b0, "R1", "reset outputs",
            64'({tck, tms, tdi, busy, done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({tck, tms, tdi, busy, done} == 5'b0, "R1", "idle after reset",
            64'({tck, tms, tdi, busy, done}), 0);

        send(2, 5, 32'h0, 2, "r7_reset", 0);
        send(0, 8, 32'h0000_00A5, 1, "dr8", 0);
        send(1, 4, 32'h0000_0006, 3, "ir4", 0);
        send(0, 32, 32'hDEAD_BEEF, 1, "dr32", 0);
        send(0, 1, 32'h0000_0001, 2, "dr1", 0);
        send(0, 0, 32'h0000_0003, 0, "R11 len0 R8 hd0", 0);
        send(1, 40, 32'h1234_5678, 1, "R11 len40", 0);
        send(3, 9, 32'hFFFF_FFFF, 1, "R7 kind3", 0);
        send(0, 20, 32'h000A_BCDE, 2, "R2 inject", 1);
        // R2: no extra scan may follow the ignored request
        n = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (busy || tck) n++;
        end
        chk(n == 0 && sb_q.size() == 0, "R2", "activity after ignored request", 64'(n), 0);
        send(1, 13, 32'h0000_1A2B, 4, "ir13", 0);
        send(0, 17, 32'h0001_5555, 3, "dr17", 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule